// File: doc/BRIEF.md
# Fully Associative Branch Target Buffer

This block is a small associative cache of branch targets. The fetch stage presents its program counter on every cycle. Within the same cycle the block reports whether that PC is a branch currently predicted taken, and gives the target to fetch from next. On a miss the sequential address is offered instead, which amounts to a not-taken guess. A redirect from the execute stage after a mispredict overrides both, so the correct instruction is fetched on the following cycle.

Only branches predicted taken are kept. The resolve logic inserts a branch, together with its target, when it resolves taken. It deletes the branch when its prediction turns to not taken. Every entry is tagged with the full PC and there are no index bits. When no slot is free, allocation follows first-in first-out order. A slot freed by a delete is filled before any live entry is evicted.

Top module: `btb_fa`

## Requirements
- R1: After reset every entry is invalid and the FIFO pointer is at slot 0. Every lookup misses until an insert is made.
- R2: When the lookup PC matches a valid entry, the block drives `hit_o`=1, `target_o` is the stored target and `next_pc_o` is that target, all in the same cycle (combinational path).
- R3: On a lookup miss, `hit_o`=0, `target_o`=0 and `next_pc_o` = lookup PC + 4.
- R4: When `redirect_i`=1, `next_pc_o` equals `redirect_pc_i` whatever the lookup result. `hit_o` and `target_o` still report the lookup.
- R5: An insert of a PC that is not present writes a new valid entry. Lookups see it from the next cycle on.
- R6: An insert of a PC that is already present replaces its target in place. It uses no new slot and leaves the FIFO pointer unchanged.
- R7: An insert of a new PC when all slots are valid overwrites the slot at the FIFO pointer, which holds the oldest entry. The pointer then advances by one and wraps from the last slot to slot 0.
- R8: A delete clears the valid bit of the matching entry, and that PC misses from the next cycle on. A delete of an absent PC changes nothing.
- R9: When some slot is invalid, a new PC goes into the lowest-numbered invalid slot. The pointer advances only if that slot is the one it points at, so no valid entry is evicted.
- R10: A lookup and an insert in the same cycle see the contents from before the insert, including when both use the same PC.
- R11: An insert and a delete of the same PC in the same cycle leave that PC absent, and no slot is allocated.
- R12: An insert and a delete of different PCs in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Lookup PC from fetch |
| hit_o | output | 1 | Lookup matched a valid entry |
| target_o | output | 32 | Stored target on a hit, else 0 |
| next_pc_o | output | 32 | Next fetch address |
| redirect_i | input | 1 | Mispredict redirect from execute |
| redirect_pc_i | input | 32 | Corrected fetch address |
| ins_valid_i | input | 1 | Insert request |
| ins_pc_i | input | 32 | PC of the branch to insert |
| ins_target_i | input | 32 | Target of the branch to insert |
| del_valid_i | input | 1 | Delete request |
| del_pc_i | input | 32 | PC of the branch to delete |

## Verification
Two functions often fall in the same cycle. A lookup can coincide with an insert, and an insert can coincide with a delete. The bench provokes the first by placing the fetch PC on the PC being inserted, in both directed and random cycles. The output is judged against a model that is still in its state from before the edge. For the second, the bench issues an insert and a delete of the same PC, and of different PCs, in one cycle. It then probes both PCs and the remaining entries on the following idle cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,
    NPC_BTB   = 2'd1,
    NPC_REDIR = 2'd2
  } npc_src_e;
endpackage

// File: rtl/btb_entry.sv
module btb_entry #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_tgt_i,
  input  logic            clr_i,
  input  logic [PC_W-1:0] lk_pc_i,
  input  logic [PC_W-1:0] ins_pc_i,
  input  logic [PC_W-1:0] del_pc_i,
  output logic            valid_o,
  output logic [PC_W-1:0] tgt_o,
  output logic            lk_hit_o,
  output logic            ins_hit_o,
  output logic            del_hit_o
);
  logic            valid_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] tgt_q;

  // write wins over clear on the same slot (evicted tag is gone anyway)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      tgt_q   <= '0;
    end else if (wr_en_i) begin
      valid_q <= 1'b1;
      pc_q    <= wr_pc_i;
      tgt_q   <= wr_tgt_i;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign tgt_o     = tgt_q;
  assign lk_hit_o  = valid_q && (pc_q == lk_pc_i);
  assign ins_hit_o = valid_q && (pc_q == ins_pc_i);
  assign del_hit_o = valid_q && (pc_q == del_pc_i);

  // R5
  entry_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q && pc_q == $past(wr_pc_i) && tgt_q == $past(wr_tgt_i));

  // R8
  entry_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_en_i) |=> !valid_q);
endmodule

// File: rtl/btb_alloc.sv
module btb_alloc #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic                   alloc_i,
  output logic [IDX_W-1:0]       victim_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic [IDX_W-1:0] ptr_inc;

  // lowest-numbered invalid slot
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_o = any_free ? free_idx : ptr_q;
  assign ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            ptr_q <= '0;
    else if (alloc_i && victim_o == ptr_q)  ptr_q <= ptr_inc;
  end

  // R7
  fifo_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !any_free) |=>
      ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

  // R9
  hole_fill_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && any_free && free_idx != ptr_q) |=> $stable(ptr_q));
endmodule

// File: rtl/btb_sel.sv
module btb_sel #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PC_W        = 32
) (
  input  logic [NUM_ENTRIES-1:0]           hit_vec_i,
  input  logic [NUM_ENTRIES-1:0][PC_W-1:0] tgt_i,
  output logic                             hit_o,
  output logic [PC_W-1:0]                  tgt_o
);
  // AND-OR mux; tags are unique so at most one term is live
  always_comb begin
    tgt_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      tgt_o = tgt_o | (tgt_i[i] & {PC_W{hit_vec_i[i]}});
    end
  end

  assign hit_o = |hit_vec_i;

  // R2
  lookup_onehot_chk: assert final ($onehot0(hit_vec_i));
endmodule

// File: rtl/btb_fa.sv
module btb_fa
  import btb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned PC_STEP     = 4,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] target_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            redirect_i,
  input  logic [PC_W-1:0] redirect_pc_i,
  input  logic            ins_valid_i,
  input  logic [PC_W-1:0] ins_pc_i,
  input  logic [PC_W-1:0] ins_target_i,
  input  logic            del_valid_i,
  input  logic [PC_W-1:0] del_pc_i
);
  logic [NUM_ENTRIES-1:0]           valid_vec;
  logic [NUM_ENTRIES-1:0]           lk_hit_vec;
  logic [NUM_ENTRIES-1:0]           ins_hit_vec;
  logic [NUM_ENTRIES-1:0]           del_hit_vec;
  logic [NUM_ENTRIES-1:0]           wr_en_vec;
  logic [NUM_ENTRIES-1:0]           clr_vec;
  logic [NUM_ENTRIES-1:0][PC_W-1:0] tgt_arr;

  logic             ins_conflict;
  logic             ins_eff;
  logic             ins_present;
  logic             alloc;
  logic [IDX_W-1:0] victim;
  npc_src_e         npc_src;

  // same-PC insert+delete: delete wins
  assign ins_conflict = ins_valid_i && del_valid_i && (ins_pc_i == del_pc_i);
  assign ins_eff      = ins_valid_i && !ins_conflict;
  assign ins_present  = |ins_hit_vec;
  assign alloc        = ins_eff && !ins_present;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    assign wr_en_vec[g] = ins_eff &&
                          (ins_present ? ins_hit_vec[g] : (victim == IDX_W'(g)));
    assign clr_vec[g]   = del_valid_i && del_hit_vec[g];

    btb_entry #(.PC_W(PC_W)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_vec[g]),
      .wr_pc_i   (ins_pc_i),
      .wr_tgt_i  (ins_target_i),
      .clr_i     (clr_vec[g]),
      .lk_pc_i   (fetch_pc_i),
      .ins_pc_i  (ins_pc_i),
      .del_pc_i  (del_pc_i),
      .valid_o   (valid_vec[g]),
      .tgt_o     (tgt_arr[g]),
      .lk_hit_o  (lk_hit_vec[g]),
      .ins_hit_o (ins_hit_vec[g]),
      .del_hit_o (del_hit_vec[g])
    );
  end

  btb_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_vec),
    .alloc_i  (alloc),
    .victim_o (victim)
  );

  btb_sel #(.NUM_ENTRIES(NUM_ENTRIES), .PC_W(PC_W)) u_sel (
    .hit_vec_i (lk_hit_vec),
    .tgt_i     (tgt_arr),
    .hit_o     (hit_o),
    .tgt_o     (target_o)
  );

  always_comb begin
    if (redirect_i)  npc_src = NPC_REDIR;
    else if (hit_o)  npc_src = NPC_BTB;
    else             npc_src = NPC_SEQ;
  end

  always_comb begin
    unique case (npc_src)
      NPC_REDIR: next_pc_o = redirect_pc_i;
      NPC_BTB:   next_pc_o = target_o;
      default:   next_pc_o = fetch_pc_i + PC_W'(PC_STEP);
    endcase
  end

  // R6
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ins_hit_vec));

  // R11
  conflict_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_conflict |=> !(|ins_hit_vec) || !($past(ins_pc_i) == ins_pc_i));
endmodule

// File: tb/btb_fa_bench.sv
module btb_fa_bench;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        hit_o;
  logic [31:0] target_o;
  logic [31:0] next_pc_o;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_pc_i = '0;
  logic        ins_valid_i = 1'b0;
  logic [31:0] ins_pc_i = '0;
  logic [31:0] ins_target_i = '0;
  logic        del_valid_i = 1'b0;
  logic [31:0] del_pc_i = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        m_valid [N];
  logic [31:0] m_pc    [N];
  logic [31:0] m_tgt   [N];
  int          m_ptr;

  always #5 clk_i = ~clk_i;

  btb_fa u_btb_fa (
    .clk_i, .rst_ni, .fetch_pc_i, .hit_o, .target_o, .next_pc_o,
    .redirect_i, .redirect_pc_i, .ins_valid_i, .ins_pc_i, .ins_target_i,
    .del_valid_i, .del_pc_i
  );

  function automatic int m_find(input logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_pc[i] == pc) return i;
    return -1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_lookup(input string tag);
    int k = m_find(fetch_pc_i);
    logic        e_hit = (k >= 0);
    logic [31:0] e_tgt = (k >= 0) ? m_tgt[k] : 32'h0;
    logic [31:0] e_npc = redirect_i ? redirect_pc_i : (e_hit ? e_tgt : fetch_pc_i + 32'd4);
    check(tag, {31'b0, hit_o}, {31'b0, e_hit}, "hit");
    check(tag, target_o, e_tgt, "target");
    check(tag, next_pc_o, e_npc, "next_pc");
  endtask

  // state change at the edge, computed from pre-edge state
  task automatic m_update();
    bit same = ins_valid_i && del_valid_i && ins_pc_i == del_pc_i;
    bit ieff = ins_valid_i && !same;
    int wslot = -1;
    int di = del_valid_i ? m_find(del_pc_i) : -1;
    if (ieff) begin
      int k = m_find(ins_pc_i);
      if (k >= 0) wslot = k;
      else begin
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) wslot = i;
        if (wslot < 0) wslot = m_ptr;
        if (wslot == m_ptr) m_ptr = (m_ptr + 1) % N;
      end
    end
    if (di >= 0 && di != wslot) m_valid[di] = 1'b0;
    if (wslot >= 0) begin
      m_valid[wslot] = 1'b1;
      m_pc[wslot]    = ins_pc_i;
      m_tgt[wslot]   = ins_target_i;
    end
  endtask

  task automatic idle();
    redirect_i = 0; ins_valid_i = 0; del_valid_i = 0;
  endtask

  // inputs set at negedge; check then clock
  task automatic cyc(input string tag);
    #1 check_lookup(tag);
    @(posedge clk_i);
    m_update();
    @(negedge clk_i);
  endtask

  task automatic probe(input logic [31:0] pc, input string tag);
    idle(); fetch_pc_i = pc; cyc(tag);
  endtask

  task automatic do_ins(input logic [31:0] pc, input logic [31:0] tgt, input string tag);
    idle(); ins_valid_i = 1; ins_pc_i = pc; ins_target_i = tgt; cyc(tag);
  endtask

  task automatic do_del(input logic [31:0] pc, input string tag);
    idle(); del_valid_i = 1; del_pc_i = pc; cyc(tag);
  endtask

  function automatic logic [31:0] pcv(input int k);
    return 32'd596 + 32'(4 * k);
  endfunction

  task automatic probe_all(input string tag);
    for (int k = 0; k < 14; k++) probe(pcv(k), tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_pc[i] = 0; m_tgt[i] = 0; end
    m_ptr = 0;
    void'($urandom(32'd20240611));
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    probe_all("R1");
    probe(32'h0, "R1");

    // fill slots 0..7 with pcv(0..7)
    for (int k = 0; k < 8; k++) do_ins(pcv(k), 32'h1000 + 32'(16 * k), "R5");
    probe_all("R2");

    // redirect overrides hit and miss
    idle(); fetch_pc_i = pcv(3); redirect_i = 1; redirect_pc_i = 32'h0000_2000; cyc("R4");
    idle(); fetch_pc_i = pcv(12); redirect_i = 1; redirect_pc_i = 32'h0000_2004; cyc("R4");
    probe(pcv(12), "R3");

    // in-place update, then new insert evicts oldest (pcv(0))
    do_ins(pcv(1), 32'hAAAA_0000, "R6");
    probe(pcv(1), "R6");
    do_ins(pcv(8), 32'h3000, "R7");
    probe(pcv(0), "R7");
    probe(pcv(1), "R6");
    do_ins(pcv(9), 32'h3004, "R7");
    probe_all("R7");

    // delete then refill hole without evicting
    do_del(pcv(4), "R8");
    probe(pcv(4), "R8");
    do_del(pcv(13), "R8");
    probe_all("R8");
    do_ins(pcv(10), 32'h4000, "R9");
    probe_all("R9");

    // same-cycle lookup+insert of a new pc
    do_del(pcv(5), "R8");
    idle(); fetch_pc_i = pcv(11); ins_valid_i = 1; ins_pc_i = pcv(11); ins_target_i = 32'h5000; cyc("R10");
    probe(pcv(11), "R10");
    idle(); fetch_pc_i = pcv(11); ins_valid_i = 1; ins_pc_i = pcv(11); ins_target_i = 32'h5100; cyc("R10");
    probe(pcv(11), "R10");

    // insert+delete same pc
    idle(); ins_valid_i = 1; ins_pc_i = pcv(12); ins_target_i = 32'h6000;
    del_valid_i = 1; del_pc_i = pcv(12); fetch_pc_i = pcv(12); cyc("R11");
    probe(pcv(12), "R11");
    idle(); ins_valid_i = 1; ins_pc_i = pcv(11); ins_target_i = 32'h6100;
    del_valid_i = 1; del_pc_i = pcv(11); fetch_pc_i = pcv(11); cyc("R11");
    probe_all("R11");

    // insert+delete different pcs
    idle(); ins_valid_i = 1; ins_pc_i = pcv(0); ins_target_i = 32'h7000;
    del_valid_i = 1; del_pc_i = pcv(2); fetch_pc_i = pcv(2); cyc("R12");
    probe_all("R12");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      string tag;
      int k;
      idle();
      fetch_pc_i   = pcv($urandom_range(13));
      ins_valid_i  = ($urandom_range(99) < 40);
      ins_pc_i     = pcv($urandom_range(13));
      ins_target_i = $urandom() & 32'hFFFF_FFFC;
      del_valid_i  = ($urandom_range(99) < 25);
      del_pc_i     = ($urandom_range(3) == 0) ? ins_pc_i : pcv($urandom_range(13));
      redirect_i   = ($urandom_range(99) < 20);
      redirect_pc_i = $urandom() & 32'hFFFF_FFFC;
      if ($urandom_range(3) == 0) fetch_pc_i = ins_pc_i;
      k = m_find(fetch_pc_i);
      if (ins_valid_i && del_valid_i && ins_pc_i == del_pc_i) tag = "R11";
      else if (ins_valid_i && fetch_pc_i == ins_pc_i) tag = "R10";
      else if (ins_valid_i && del_valid_i) tag = "R12";
      else if (redirect_i) tag = "R4";
      else if (k >= 0) tag = "R2";
      else tag = "R3";
      cyc(tag);
    end
    probe_all("R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule